// File: doc/BRIEF.md
# Clock Lane High-Speed Transmit Sequencer

This block runs the clock lane of a serial display transmitter. It takes the lane from the low-power stop state into continuous high-speed clocking and back again. Every phase length is a programmable count of byte-clock periods, where one byte clock equals eight high-speed bit periods. The block drives the low-power line pair, the enables for the low-power and high-speed drivers, and a gate that lets the high-speed clock reach the pins. It also raises a flag once the clock has run long enough for the data lanes to start.

The upstream controller holds `hs_req` high to ask for clocking and drops it to ask for a stop. Entry only starts once the analog bias reports ready.

Entry passes through these phases in order:
- stop, with the lines at LP-11;
- LP-01 for the LPX count;
- LP-00 for the LPX count;
- HS-0 for the prepare count;
- HS-0 for the zero count;
- a pre phase in which the clock runs;
- the running state, in which the data lanes may go.

Exit passes through these phases in order:
- a post phase in which the clock keeps running;
- a trail phase at HS-0 with the clock gated off;
- back to LP-11.

Each of the two driver enables can be taken over by a select bit and a value bit. A power-down input and a lane soft reset both return the sequencer to stop.

Top module: `clkln_hs_seq`

## Requirements
- R1: After `rst`, the outputs show the stop state: `lp_dp`=1, `lp_dn`=1, `tx_lp_en`=1, `tx_hs_en`=0, `hs_clk_gate`=0, `data_go`=0. Once `mbias_ready` is high, `lane_status` reads 4'b1100.
- R2: The sequencer leaves stop only while `hs_req` and `mbias_ready` are both high. `lane_status[3]` follows `mbias_ready`, one cycle late.
- R3: Entry drives LP-01 (`lp_dp`=0, `lp_dn`=1, `tx_lp_en`=1) for `lpx_cnt` cycles and then LP-00 for `lpx_cnt` cycles. The LP-01 phase starts on the cycle after `hs_req` is sampled high.
- R4: After LP-00, the lane drives HS-0 (`tx_hs_en`=1, lines 00, gate off). This lasts for the prepare count (`tim_word[31:24]`) plus the zero count (`tim_word[23:16]`).
- R5: Next, `hs_clk_gate` and `lane_status[0]` rise while `data_go` stays low for `pre_cnt` cycles. `data_go` then goes high, and it is only ever high while the gate is on.
- R6: In the running state, a low `hs_req` starts the exit on the next cycle. The exit keeps the clock gated on for the post count (`tim_word[15:8]`), then holds HS-0 with the gate off for the trail count (`tim_word[7:0]`), then returns to LP-11. Once the exit has started, a new `hs_req` does not shorten it, and a low `hs_req` during pre does not skip the running state.
- R7: A count of zero in any field gives a phase of one cycle.
- R8: While `hs_en_sel` is 1, `tx_hs_en` equals `hs_en_val` from the previous cycle, whatever the sequencer state. The clock gate is not affected by this override.
- R9: While `lp_en_sel` is 1, `tx_lp_en` equals `lp_en_val` from the previous cycle. The two overrides are independent of each other.
- R10: On the cycle after `pwr_down` is high, the following are all 0, overriding the selects: `tx_lp_en`, `tx_hs_en`, `hs_clk_gate`, `data_go`, `lp_dp`, `lp_dn`, `lane_status[2]` and `lane_status[0]`. After release, the lane is in stop.
- R11: A high `lane_srst` returns the lane to the stop state on the next cycle.
- R12: `lane_status` is {bias ready, in stop, ultra-low-power (always 0), high-speed clock active}. The in-stop bit and the active bit are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_srst | input | 1 | Lane soft reset, synchronous |
| pwr_down | input | 1 | Lane and PHY power down |
| mbias_ready | input | 1 | Analog bias ready |
| hs_req | input | 1 | 1 requests HS clocking, 0 requests stop |
| tim_word | input | 32 | Packed counts: prepare 31:24, zero 23:16, post 15:8, trail 7:0 |
| pre_cnt | input | 8 | Clock run time before the data lanes may go |
| lpx_cnt | input | 8 | Length of each low-power entry step |
| hs_en_sel | input | 1 | 1 selects `hs_en_val` for `tx_hs_en` |
| hs_en_val | input | 1 | Override value for `tx_hs_en` |
| lp_en_sel | input | 1 | 1 selects `lp_en_val` for `tx_lp_en` |
| lp_en_val | input | 1 | Override value for `tx_lp_en` |
| lp_dp | output | 1 | Low-power positive line level |
| lp_dn | output | 1 | Low-power negative line level |
| tx_lp_en | output | 1 | Low-power driver enable |
| tx_hs_en | output | 1 | High-speed driver enable |
| hs_clk_gate | output | 1 | High-speed clock gate |
| data_go | output | 1 | Pre has elapsed and the data lanes may start |
| lane_status | output | 4 | {bias ready, in stop, ultra-low-power, HS active} |

## Verification
Two events can fall on the same cycle: a stop request arriving, and the pre count expiring. The bench sets the pre count to one and drops `hs_req` on the very sample where the pre phase first appears. It then expects exactly one running cycle with `data_go` high, followed by the full post and trail phases. A second case raises `hs_req` again during post and expects post, trail and one stop cycle before a new LP-01 begins. A third case sets both override selects at the same time as power down and expects every enable to be forced low.

// File: rtl/clkln_pkg.sv
package clkln_pkg;

  typedef enum logic [3:0] {
    ST_STOP  = 4'd0,
    ST_LP01  = 4'd1,
    ST_LP00  = 4'd2,
    ST_PREP  = 4'd3,
    ST_ZERO  = 4'd4,
    ST_PRE   = 4'd5,
    ST_RUN   = 4'd6,
    ST_POST  = 4'd7,
    ST_TRAIL = 4'd8
  } clk_st_e;

  typedef struct packed {
    logic dp;
    logic dn;
    logic lp_en;
    logic hs_en;
    logic gate;
    logic data_ok;
    logic active;
    logic stop;
  } lane_drv_s;

  function automatic lane_drv_s lane_decode(clk_st_e s);
    lane_drv_s d;
    d = '0;
    case (s)
      ST_STOP: begin
        d.dp = 1'b1; d.dn = 1'b1; d.lp_en = 1'b1; d.stop = 1'b1;
      end
      ST_LP01: begin
        d.dn = 1'b1; d.lp_en = 1'b1;
      end
      ST_LP00: d.lp_en = 1'b1;
      ST_PREP, ST_ZERO, ST_TRAIL: d.hs_en = 1'b1;
      ST_PRE, ST_POST: begin
        d.hs_en = 1'b1; d.gate = 1'b1; d.active = 1'b1;
      end
      ST_RUN: begin
        d.hs_en = 1'b1; d.gate = 1'b1; d.active = 1'b1; d.data_ok = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/clkln_phase_timer.sv
module clkln_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] dur_m1,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q == dur_m1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/clkln_fsm.sv
module clkln_fsm
  import clkln_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lane_srst,
  input  logic             pwr_down,
  input  logic             mbias_ready,
  input  logic             hs_req,
  input  logic [CNT_W-1:0] lpx,
  input  logic [CNT_W-1:0] prep,
  input  logic [CNT_W-1:0] zero,
  input  logic [CNT_W-1:0] pre,
  input  logic [CNT_W-1:0] post,
  input  logic [CNT_W-1:0] trail,
  output clk_st_e          state_q,
  output clk_st_e          state_d
);

  logic [CNT_W-1:0] raw_cnt;
  logic [CNT_W-1:0] dur_m1;
  logic             ph_done;
  logic             restart;

  always_comb begin
    case (state_q)
      ST_LP01, ST_LP00: raw_cnt = lpx;
      ST_PREP:          raw_cnt = prep;
      ST_ZERO:          raw_cnt = zero;
      ST_PRE:           raw_cnt = pre;
      ST_POST:          raw_cnt = post;
      ST_TRAIL:         raw_cnt = trail;
      default:          raw_cnt = '0;
    endcase
    dur_m1 = (raw_cnt == '0) ? '0 : raw_cnt - 1'b1;
  end

  always_comb begin
    state_d = state_q;
    if (pwr_down || lane_srst) begin
      state_d = ST_STOP;
    end else begin
      case (state_q)
        ST_STOP:  if (hs_req && mbias_ready) state_d = ST_LP01;
        ST_LP01:  if (ph_done) state_d = ST_LP00;
        ST_LP00:  if (ph_done) state_d = ST_PREP;
        ST_PREP:  if (ph_done) state_d = ST_ZERO;
        ST_ZERO:  if (ph_done) state_d = ST_PRE;
        ST_PRE:   if (ph_done) state_d = ST_RUN;
        ST_RUN:   if (!hs_req) state_d = ST_POST;
        ST_POST:  if (ph_done) state_d = ST_TRAIL;
        ST_TRAIL: if (ph_done) state_d = ST_STOP;
        default:  state_d = ST_STOP;
      endcase
    end
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_STOP;
    end else begin
      state_q <= state_d;
    end
  end

  clkln_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .dur_m1  (dur_m1),
    .done    (ph_done)
  );

endmodule

// File: rtl/clkln_drive.sv
module clkln_drive
  import clkln_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  clk_st_e    state_d,
  input  logic       pwr_down,
  input  logic       mbias_ready,
  input  logic       hs_en_sel,
  input  logic       hs_en_val,
  input  logic       lp_en_sel,
  input  logic       lp_en_val,
  output logic       lp_dp,
  output logic       lp_dn,
  output logic       tx_lp_en,
  output logic       tx_hs_en,
  output logic       hs_clk_gate,
  output logic       data_go,
  output logic [3:0] lane_status
);

  lane_drv_s nxt;

  assign nxt = lane_decode(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_dp       <= 1'b1;
      lp_dn       <= 1'b1;
      tx_lp_en    <= 1'b1;
      tx_hs_en    <= 1'b0;
      hs_clk_gate <= 1'b0;
      data_go     <= 1'b0;
      lane_status <= 4'b0100;
    end else if (pwr_down) begin
      lp_dp       <= 1'b0;
      lp_dn       <= 1'b0;
      tx_lp_en    <= 1'b0;
      tx_hs_en    <= 1'b0;
      hs_clk_gate <= 1'b0;
      data_go     <= 1'b0;
      lane_status <= {mbias_ready, 3'b000};
    end else begin
      lp_dp       <= nxt.dp;
      lp_dn       <= nxt.dn;
      tx_lp_en    <= lp_en_sel ? lp_en_val : nxt.lp_en;
      tx_hs_en    <= hs_en_sel ? hs_en_val : nxt.hs_en;
      hs_clk_gate <= nxt.gate;
      data_go     <= nxt.data_ok;
      lane_status <= {mbias_ready, nxt.stop, 1'b0, nxt.active};
    end
  end

endmodule

// File: rtl/clkln_hs_seq.sv
module clkln_hs_seq
  import clkln_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int N_FLD  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lane_srst,
  input  logic                   pwr_down,
  input  logic                   mbias_ready,
  input  logic                   hs_req,
  input  logic [N_FLD*CNT_W-1:0] tim_word,
  input  logic [CNT_W-1:0]       pre_cnt,
  input  logic [CNT_W-1:0]       lpx_cnt,
  input  logic                   hs_en_sel,
  input  logic                   hs_en_val,
  input  logic                   lp_en_sel,
  input  logic                   lp_en_val,
  output logic                   lp_dp,
  output logic                   lp_dn,
  output logic                   tx_lp_en,
  output logic                   tx_hs_en,
  output logic                   hs_clk_gate,
  output logic                   data_go,
  output logic [3:0]             lane_status
);

  localparam int F_TRAIL = 0;
  localparam int F_POST  = 1;
  localparam int F_ZERO  = 2;
  localparam int F_PREP  = 3;

  logic [CNT_W-1:0] fld [N_FLD];
  clk_st_e          st_q;
  clk_st_e          st_d;

  for (genvar gi = 0; gi < N_FLD; gi++) begin : g_fld
    assign fld[gi] = tim_word[gi*CNT_W +: CNT_W];
  end

  clkln_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .lane_srst   (lane_srst),
    .pwr_down    (pwr_down),
    .mbias_ready (mbias_ready),
    .hs_req      (hs_req),
    .lpx         (lpx_cnt),
    .prep        (fld[F_PREP]),
    .zero        (fld[F_ZERO]),
    .pre         (pre_cnt),
    .post        (fld[F_POST]),
    .trail       (fld[F_TRAIL]),
    .state_q     (st_q),
    .state_d     (st_d)
  );

  clkln_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .state_d     (st_d),
    .pwr_down    (pwr_down),
    .mbias_ready (mbias_ready),
    .hs_en_sel   (hs_en_sel),
    .hs_en_val   (hs_en_val),
    .lp_en_sel   (lp_en_sel),
    .lp_en_val   (lp_en_val),
    .lp_dp       (lp_dp),
    .lp_dn       (lp_dn),
    .tx_lp_en    (tx_lp_en),
    .tx_hs_en    (tx_hs_en),
    .hs_clk_gate (hs_clk_gate),
    .data_go     (data_go),
    .lane_status (lane_status)
  );

endmodule

// File: rtl/clkln_hs_seq_chk.sv
module clkln_hs_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       lane_srst,
  input logic       pwr_down,
  input logic       hs_en_sel,
  input logic       hs_en_val,
  input logic       lp_en_sel,
  input logic       lp_en_val,
  input logic       lp_dp,
  input logic       lp_dn,
  input logic       tx_lp_en,
  input logic       tx_hs_en,
  input logic       hs_clk_gate,
  input logic       data_go,
  input logic [3:0] lane_status
);

  AST_DATA_GO_GATED: assert property (@(posedge clk) disable iff (rst)
    data_go |-> hs_clk_gate); // R5

  AST_GATE_WITH_HS: assert property (@(posedge clk) disable iff (rst)
    (hs_clk_gate && !$past(hs_en_sel)) |-> tx_hs_en); // R5

  AST_LP01_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    ($fell(lp_dp) && lp_dn) |-> ($past(lp_dp) && $past(lp_dn))); // R3

  AST_HS_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    ($past(hs_en_sel) && !$past(pwr_down) && !$past(rst)) |-> (tx_hs_en == $past(hs_en_val))); // R8

  AST_LP_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    ($past(lp_en_sel) && !$past(pwr_down) && !$past(rst)) |-> (tx_lp_en == $past(lp_en_val))); // R9

  AST_PDN_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_down) && !$past(rst)) |-> (!tx_lp_en && !tx_hs_en && !hs_clk_gate && !lane_status[2])); // R10

  AST_SRST_STOP: assert property (@(posedge clk) disable iff (rst)
    ($past(lane_srst) && !$past(pwr_down) && !$past(rst)) |-> (lane_status[2] && lp_dp && lp_dn)); // R11

  AST_STOP_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    lane_status[2] |-> !lane_status[0]); // R12

endmodule

bind clkln_hs_seq clkln_hs_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .lane_srst   (lane_srst),
  .pwr_down    (pwr_down),
  .hs_en_sel   (hs_en_sel),
  .hs_en_val   (hs_en_val),
  .lp_en_sel   (lp_en_sel),
  .lp_en_val   (lp_en_val),
  .lp_dp       (lp_dp),
  .lp_dn       (lp_dn),
  .tx_lp_en    (tx_lp_en),
  .tx_hs_en    (tx_hs_en),
  .hs_clk_gate (hs_clk_gate),
  .data_go     (data_go),
  .lane_status (lane_status)
);

// File: tb/clkln_hs_seq_bench.sv
`timescale 1ns/1ps
module clkln_hs_seq_bench;

  logic        clk = 1'b0;
  logic        rst, lane_srst, pwr_down, mbias_ready, hs_req;
  logic [31:0] tim_word;
  logic [7:0]  pre_cnt, lpx_cnt;
  logic        hs_en_sel, hs_en_val, lp_en_sel, lp_en_val;
  logic        lp_dp, lp_dn, tx_lp_en, tx_hs_en, hs_clk_gate, data_go;
  logic [3:0]  lane_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  clkln_hs_seq u_clkln_hs_seq (
    .clk(clk), .rst(rst), .lane_srst(lane_srst), .pwr_down(pwr_down),
    .mbias_ready(mbias_ready), .hs_req(hs_req), .tim_word(tim_word),
    .pre_cnt(pre_cnt), .lpx_cnt(lpx_cnt), .hs_en_sel(hs_en_sel),
    .hs_en_val(hs_en_val), .lp_en_sel(lp_en_sel), .lp_en_val(lp_en_val),
    .lp_dp(lp_dp), .lp_dn(lp_dn), .tx_lp_en(tx_lp_en), .tx_hs_en(tx_hs_en),
    .hs_clk_gate(hs_clk_gate), .data_go(data_go), .lane_status(lane_status)
  );

  // output pattern {dp, dn, lp_en, hs_en, gate, data_go}
  localparam logic [5:0] P_STOP = 6'b111000;
  localparam logic [5:0] P_LP01 = 6'b011000;
  localparam logic [5:0] P_LP00 = 6'b001000;
  localparam logic [5:0] P_HS0  = 6'b000100;
  localparam logic [5:0] P_CLK  = 6'b000110;
  localparam logic [5:0] P_RUN  = 6'b000111;

  // {lpx, prep, zero, pre, post, trail, e_lpx, e_hs0, e_pre, e_post, e_trail}
  localparam int NV = 5;
  localparam logic [87:0] VEC [NV] = '{
    {8'd1,  8'd1, 8'd1,  8'd1, 8'd1, 8'd1,  8'd1,  8'd2,  8'd1, 8'd1, 8'd1},
    {8'd0,  8'd0, 8'd0,  8'd0, 8'd0, 8'd0,  8'd1,  8'd2,  8'd1, 8'd1, 8'd1},
    {8'd3,  8'd2, 8'd5,  8'd4, 8'd2, 8'd3,  8'd3,  8'd7,  8'd4, 8'd2, 8'd3},
    {8'd2,  8'd0, 8'd4,  8'd0, 8'd6, 8'd1,  8'd2,  8'd5,  8'd1, 8'd6, 8'd1},
    {8'd10, 8'd7, 8'd20, 8'd9, 8'd3, 8'd12, 8'd10, 8'd27, 8'd9, 8'd3, 8'd12}
  };

  function automatic logic [5:0] pat();
    return {lp_dp, lp_dn, tx_lp_en, tx_hs_en, hs_clk_gate, data_go};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input logic [5:0] p, output int n);
    n = 0;
    while (pat() == p && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_tim(input int lpx, input int prep, input int zero,
                         input int pre, input int post, input int trail);
    lpx_cnt  = 8'(lpx);
    pre_cnt  = 8'(pre);
    tim_word = {8'(prep), 8'(zero), 8'(post), 8'(trail)};
  endtask

  task automatic reach_run();
    int k;
    k = 0;
    hs_req = 1'b1;
    while (pat() != P_RUN && k < 500) begin
      k++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; lane_srst = 1'b0; pwr_down = 1'b0; mbias_ready = 1'b1;
    hs_req = 1'b0; hs_en_sel = 1'b0; hs_en_val = 1'b0;
    lp_en_sel = 1'b0; lp_en_val = 1'b0;
    set_tim(1, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R1: reset state
    check("R1 reset pattern", int'(pat()), int'(P_STOP));
    check("R1 reset status", int'(lane_status), 4'b1100);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [87:0] v;
      string tg;
      v = VEC[i];
      tg = (i == 1) ? "R7" : "R3";
      set_tim(v[87:80], v[79:72], v[71:64], v[63:56], v[55:48], v[47:40]);
      hs_req = 1'b1;
      @(negedge clk);
      run_len(P_LP01, n); check({tg, " lp01 len"}, n, int'(v[39:32]));
      run_len(P_LP00, n); check({tg, " lp00 len"}, n, int'(v[39:32]));
      run_len(P_HS0, n);  check("R4 hs0 len", n, int'(v[31:24]));
      run_len(P_CLK, n);  check("R5 pre len", n, int'(v[23:16]));
      check("R12 run status", int'(lane_status), 4'b1001);
      repeat (2) @(negedge clk);
      hs_req = 1'b0;
      run_len(P_RUN, n);  check("R6 run len after drop", n, 3'd1);
      run_len(P_CLK, n);  check("R6 post len", n, int'(v[15:8]));
      run_len(P_HS0, n);  check("R6 trail len", n, int'(v[7:0]));
      check("R6 back to stop", int'(pat()), int'(P_STOP));
      @(negedge clk);
    end

    // R2: entry blocked while bias not ready
    mbias_ready = 1'b0;
    @(negedge clk);
    hs_req = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 held in stop", int'(pat()), int'(P_STOP));
    check("R2 status bias low", int'(lane_status), 4'b0100);
    mbias_ready = 1'b1;
    @(negedge clk);
    check("R2 entry after bias", int'(pat()), int'(P_LP01));

    // R11: soft reset mid-entry
    @(negedge clk);
    lane_srst = 1'b1; hs_req = 1'b0;
    @(negedge clk);
    check("R11 soft reset stop", int'(pat()), int'(P_STOP));
    check("R11 status stop", int'(lane_status), 4'b1100);
    lane_srst = 1'b0;
    @(negedge clk);

    // R6: stop request on the final pre cycle
    set_tim(1, 1, 1, 1, 2, 1);
    hs_req = 1'b1;
    @(negedge clk);
    run_len(P_LP01, n); run_len(P_LP00, n); run_len(P_HS0, n);
    hs_req = 1'b0;
    run_len(P_CLK, n);  check("R6 pre with drop", n, 1);
    run_len(P_RUN, n);  check("R6 single run cycle", n, 1);
    run_len(P_CLK, n);  check("R6 post after late drop", n, 2);
    run_len(P_HS0, n);  check("R6 trail after late drop", n, 1);
    @(negedge clk);

    // R6: new request during post does not cut it short
    set_tim(1, 1, 1, 1, 4, 2);
    reach_run();
    hs_req = 1'b0;
    run_len(P_RUN, n);
    hs_req = 1'b1;
    run_len(P_CLK, n);  check("R6 post not aborted", n, 4);
    run_len(P_HS0, n);  check("R6 trail not aborted", n, 2);
    run_len(P_STOP, n); check("R6 one stop cycle", n, 1);
    check("R6 re-entry", int'(pat()), int'(P_LP01));
    lane_srst = 1'b1; hs_req = 1'b0;
    @(negedge clk);
    lane_srst = 1'b0;
    @(negedge clk);

    // R8 R9: overrides in stop
    hs_en_sel = 1'b1; hs_en_val = 1'b1;
    @(negedge clk);
    check("R8 hs override on", int'(tx_hs_en), 1);
    check("R9 lp untouched", int'(tx_lp_en), 1);
    lp_en_sel = 1'b1; lp_en_val = 1'b0;
    @(negedge clk);
    check("R9 lp override off", int'(tx_lp_en), 0);
    check("R8 hs still forced", int'(tx_hs_en), 1);
    hs_en_sel = 1'b0;
    @(negedge clk);
    check("R8 hs back to sequencer", int'(tx_hs_en), 0);
    check("R9 lp override independent", int'(tx_lp_en), 0);
    lp_en_sel = 1'b0;
    @(negedge clk);
    check("R9 lp released", int'(tx_lp_en), 1);

    // R8: override in run leaves gate on
    set_tim(1, 1, 1, 1, 1, 1);
    reach_run();
    hs_en_sel = 1'b1; hs_en_val = 1'b0;
    @(negedge clk);
    check("R8 hs forced off in run", int'(tx_hs_en), 0);
    check("R8 gate unaffected", int'(hs_clk_gate), 1);

    // R10: power down beats overrides
    hs_en_val = 1'b1; lp_en_sel = 1'b1; lp_en_val = 1'b1;
    pwr_down = 1'b1;
    @(negedge clk);
    check("R10 outputs quiet", int'(pat()), 0);
    check("R10 status", int'(lane_status), 4'b1000);
    pwr_down = 1'b0; hs_req = 1'b0; hs_en_sel = 1'b0; lp_en_sel = 1'b0;
    @(negedge clk);
    check("R10 stop after release", int'(pat()), int'(P_STOP));
    check("R12 status after release", int'(lane_status), 4'b1100);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule